// File: doc/BRIEF.md
# Four-Channel Programmable Sound Generator

This block makes four square-wave or noise voices for a small computer's audio path. A voice has two 8-bit registers. One is a divider value that sets the pitch. The other holds a 4-bit loudness and a 3-bit waveform code. A global register is shared by all voices. It picks the base clock of each voice, joins pairs of voices into 16-bit dividers for low or very precise pitches, chooses the length of the long noise polynomial, and can add a high-pass stage to voice 1 that is clocked by voice 2. Each voice drives a 4-bit level output. Mixing to analog is done outside the block.

The block runs on the system clock. `tick_fast` is a one-cycle enable at the fast audio rate. A prescaler divides that enable down to make the slow base rate. Register writes come in on a plain write strobe. The block takes one write on every cycle and never applies back-pressure, so there is no ready signal. Writes are the only data that flows in. The level outputs change continuously and carry no valid flag.

Top module: `sound_gen_quad`

## Requirements
- R1: After reset, all divider, control and global registers are zero, the square flip-flops and the high-pass flip-flop are 0, the polynomial registers are all ones, and every level output is 0.
- R2: A write at an offset 0–7 goes to voice (offset/2)+1. An even offset writes the divider value, and an odd offset writes the control register. In the control register, bits 3..0 are the volume and bits 6..4 are the waveform code. Offset 8 writes the global register. A write at offsets 9–15 changes nothing.
- R3: A voice divider counts down once on every base tick. When it underflows from 0, it reloads with its divider value, so a divider value N gives one underflow every N+1 base ticks. With waveform code 000, the voice's flip-flop toggles on every underflow.
- R4: The level output of a voice is its volume when the voice's output bit is 1, and 0 otherwise.
- R5: Voices 1 and 3 take the fast enable as their base tick when global bit 2 is set. Voices 2 and 4 do the same when global bit 5 is set. Otherwise a voice's base tick is the slow tick, which fires on every PRESCALE-th fast enable.
- R6: When global bit 1's neighbour, bit 0, is set, voices 1 and 2 form one 16-bit divider, clocked by voice 1's base tick. Voice 2's value is the high byte. Voice 1 produces the sound, and voice 2's level is 0.
- R7: When global bit 1 is set, voices 3 and 4 are joined in the same way. Voice 3 is the low byte and produces the sound, and voice 4's level is 0.
- R8: There are four polynomial registers of 4, 5, 9 and 17 bits. They shift right once on every fast enable. The new top bit is bit 0 XOR bit k, with k equal to 1, 2, 4 and 3 respectively, and the output of each is its bit 0. On an underflow, waveform code 001 toggles the voice only when the 5-bit output is 1. Code 010 toggles only when the 4-bit output is 1. Code 011 toggles only when both are 1.
- R9: If waveform code bit 2 is set, the long-noise bit is used. This bit is the 17-bit output when global bit 7 is set, and the 9-bit output otherwise. On an underflow, codes with bit 0 clear load the flip-flop with the long-noise bit. Codes with bit 0 set load it only when the 5-bit output is 1, and hold it otherwise.
- R10: On every voice 2 underflow, the high-pass flip-flop samples voice 1's flip-flop. When global bit 4 is set, voice 1's output bit is its flip-flop XOR the high-pass flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_fast | input | 1 | Fast audio-rate enable, one cycle wide |
| wr_en | input | 1 | Register write strobe, taken every cycle |
| wr_addr | input | 4 | Register offset |
| wr_data | input | 8 | Register write data |
| level_o | output | 16 | Voice levels; voice n sits on bits 4n-1..4n-4 |

## Verification
A register write takes effect at the clock edge that samples it. Volume, muting and the high-pass select reach `level_o` in the same cycle, after that edge. A new divider value only takes effect at the next reload. A reload, a flip-flop change or a polynomial step shows on `level_o` directly after the edge where its base tick or fast enable was high. The bench therefore advances its own model of the requirements at each rising edge from the same inputs. It compares all four levels at every falling edge, and it measures pitch as the number of falling edges between level changes.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int NCH   = 4;
  localparam int DIVW  = 8;
  localparam int VOLW  = 4;
  localparam int ADDRW = 4;
  localparam int CHW   = $clog2(NCH);

  localparam logic [ADDRW-1:0] GLOB_ADDR = ADDRW'(2 * NCH);

  // global register bit positions (behaviour depends on them)
  localparam int G_JOIN_BASE = 0;  // bit 0 joins voices 1+2, bit 1 joins 3+4
  localparam int G_FAST13    = 2;
  localparam int G_HIPASS    = 4;
  localparam int G_FAST24    = 5;
  localparam int G_POLY17    = 7;

  typedef struct packed {
    logic [2:0]      wave;
    logic [VOLW-1:0] vol;
  } voice_ctl_t;

  // next state of a voice flip-flop on an underflow
  function automatic logic voice_next(input logic cur, input logic [2:0] wave,
                                      input logic n4, input logic n5, input logic nlong);
    logic r;
    if (wave[2]) begin
      r = wave[0] ? (n5 ? nlong : cur) : nlong;
    end else begin
      case (wave[1:0])
        2'b00:   r = ~cur;
        2'b01:   r = n5 ? ~cur : cur;
        2'b10:   r = n4 ? ~cur : cur;
        default: r = (n5 & n4) ? ~cur : cur;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/sg_lfsr.sv
module sg_lfsr #(
  parameter int LEN = 5,
  parameter int TAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  output logic bit_o
);
  logic [LEN-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sr <= '1;
    else if (adv) sr <= {sr[0] ^ sr[TAP], sr[LEN-1:1]};
  end

  assign bit_o = sr[0];

  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> sr[LEN-2:0] == $past(sr[LEN-1:1]));
endmodule

// File: rtl/sg_timebase.sv
module sg_timebase #(
  parameter int PRESCALE = 28
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_fast,
  output logic slow_tick,
  output logic n4,
  output logic n5,
  output logic n9,
  output logic n17
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);

  logic [PW-1:0] pre_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (tick_fast) pre_q <= (pre_q == PLAST) ? '0 : pre_q + 1'b1;
  end

  assign slow_tick = tick_fast && (pre_q == PLAST);

  sg_lfsr #(.LEN(4),  .TAP(1)) u_p4  (.clk(clk), .rst_n(rst_n), .adv(tick_fast), .bit_o(n4));
  sg_lfsr #(.LEN(5),  .TAP(2)) u_p5  (.clk(clk), .rst_n(rst_n), .adv(tick_fast), .bit_o(n5));
  sg_lfsr #(.LEN(9),  .TAP(4)) u_p9  (.clk(clk), .rst_n(rst_n), .adv(tick_fast), .bit_o(n9));
  sg_lfsr #(.LEN(17), .TAP(3)) u_p17 (.clk(clk), .rst_n(rst_n), .adv(tick_fast), .bit_o(n17));

  p_pre_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= PLAST);

  if (PRESCALE > 1) begin : g_gap
    p_slow_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      slow_tick |=> !slow_tick);
  end
endmodule

// File: rtl/sg_pair_div.sv
module sg_pair_div #(
  parameter int DIVW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            join_en,
  input  logic            tick_lo,
  input  logic            tick_hi,
  input  logic [DIVW-1:0] div_lo,
  input  logic [DIVW-1:0] div_hi,
  output logic            uf_lo,
  output logic            uf_hi
);
  localparam int WW = 2 * DIVW;

  logic [DIVW-1:0] cnt_lo, cnt_hi;
  logic [WW-1:0]   wide;

  assign wide  = {cnt_hi, cnt_lo};
  assign uf_lo = tick_lo && (join_en ? (wide == '0) : (cnt_lo == '0));
  assign uf_hi = !join_en && tick_hi && (cnt_hi == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else if (join_en) begin
      if (tick_lo) {cnt_hi, cnt_lo} <= uf_lo ? {div_hi, div_lo} : wide - 1'b1;
    end else begin
      if (tick_lo) cnt_lo <= uf_lo ? div_lo : cnt_lo - 1'b1;
      if (tick_hi) cnt_hi <= uf_hi ? div_hi : cnt_hi - 1'b1;
    end
  end

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_lo && !tick_hi) |=> ($stable(cnt_lo) && $stable(cnt_hi)));

  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!join_en && tick_lo && !uf_lo) |=> cnt_lo == DIVW'($past(cnt_lo) - 1'b1));

  p_join_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (join_en && uf_lo) |=> wide == $past({div_hi, div_lo}));
endmodule

// File: rtl/sg_voice.sv
module sg_voice
  import sg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       uf,
  input  logic [2:0] wave,
  input  logic       n4,
  input  logic       n5,
  input  logic       nlong,
  output logic       out_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  out_bit <= 1'b0;
    else if (uf) out_bit <= voice_next(out_bit, wave, n4, n5, nlong);
  end

  p_tone_toggle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && wave == 3'b000) |=> out_bit != $past(out_bit));

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !uf |=> $stable(out_bit));

  p_poly4_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && wave == 3'b010 && !n4) |=> $stable(out_bit));
endmodule

// File: rtl/sound_gen_quad.sv
module sound_gen_quad
  import sg_pkg::*;
#(
  parameter int PRESCALE = 28
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_fast,
  input  logic              wr_en,
  input  logic [ADDRW-1:0]  wr_addr,
  input  logic [7:0]        wr_data,
  output logic [NCH*VOLW-1:0] level_o
);
  logic [DIVW-1:0] freq_q [NCH];
  voice_ctl_t      ctl_q  [NCH];
  logic [7:0]      glob_q;
  logic            hp_q;

  logic            slow_tick, n4, n5, n9, n17, nlong;
  logic [NCH-1:0]  base_tick, uf, vbit;
  logic            wr_voice;
  logic [CHW-1:0]  wr_idx;

  assign wr_voice = wr_en && (wr_addr < GLOB_ADDR);
  assign wr_idx   = wr_addr[CHW:1];

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        freq_q[i] <= '0;
        ctl_q[i]  <= '0;
      end
      glob_q <= '0;
    end else begin
      if (wr_voice) begin
        if (wr_addr[0]) ctl_q[wr_idx]  <= voice_ctl_t'(wr_data[6:0]);
        else            freq_q[wr_idx] <= wr_data;
      end
      if (wr_en && wr_addr == GLOB_ADDR) glob_q <= wr_data;
    end
  end

  sg_timebase #(.PRESCALE(PRESCALE)) u_tb (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .slow_tick(slow_tick),
    .n4(n4), .n5(n5), .n9(n9), .n17(n17)
  );

  assign nlong = glob_q[G_POLY17] ? n17 : n9;

  for (genvar c = 0; c < NCH; c++) begin : g_base
    localparam int SELB = (c % 2 == 0) ? G_FAST13 : G_FAST24;
    assign base_tick[c] = glob_q[SELB] ? tick_fast : slow_tick;
  end

  for (genvar p = 0; p < NCH / 2; p++) begin : g_pair
    sg_pair_div #(.DIVW(DIVW)) u_div (
      .clk(clk), .rst_n(rst_n), .join_en(glob_q[G_JOIN_BASE + p]),
      .tick_lo(base_tick[2*p]), .tick_hi(base_tick[2*p+1]),
      .div_lo(freq_q[2*p]), .div_hi(freq_q[2*p+1]),
      .uf_lo(uf[2*p]), .uf_hi(uf[2*p+1])
    );
  end

  for (genvar c = 0; c < NCH; c++) begin : g_voice
    sg_voice u_voice (
      .clk(clk), .rst_n(rst_n), .uf(uf[c]), .wave(ctl_q[c].wave),
      .n4(n4), .n5(n5), .nlong(nlong), .out_bit(vbit[c])
    );
  end

  // high-pass stage on voice 1, clocked by voice 2
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hp_q <= 1'b0;
    else if (uf[1]) hp_q <= vbit[0];
  end

  for (genvar c = 0; c < NCH; c++) begin : g_level
    logic eff, mute;
    if (c == 0) begin : g_hp
      assign eff = glob_q[G_HIPASS] ? (vbit[0] ^ hp_q) : vbit[0];
    end else begin : g_plain
      assign eff = vbit[c];
    end
    if (c % 2 == 1) begin : g_hi
      assign mute = glob_q[G_JOIN_BASE + c/2];
    end else begin : g_lo
      assign mute = 1'b0;
    end
    assign level_o[c*VOLW +: VOLW] = (eff && !mute) ? ctl_q[c].vol : '0;

    p_level_vol_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o[c*VOLW +: VOLW] == '0) || (level_o[c*VOLW +: VOLW] == ctl_q[c].vol));
  end

  p_glob_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == GLOB_ADDR) |=> glob_q == $past(wr_data));

  p_high_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en || wr_addr > GLOB_ADDR) |=> $stable(glob_q));

  p_hp_sample_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uf[1] |=> hp_q == $past(vbit[0]));

  p_pair_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    glob_q[G_JOIN_BASE + 1] |-> !uf[3]);
endmodule

// File: tb/sound_gen_quad_test.sv
`timescale 1ns/1ps
module sound_gen_quad_test;
  localparam int PRE = 28;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_fast = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [15:0] level_o;

  int checks = 0;
  int failures = 0;
  bit cmp_en = 1'b0;
  string phase = "R1";

  always #2 clk = ~clk;

  sound_gen_quad #(.PRESCALE(PRE)) uut (
    .clk(clk), .rst_n(rst_n), .tick_fast(tick_fast), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .level_o(level_o)
  );

  // ---------------- reference model built from the requirements
  logic [7:0]  m_freq [4];
  logic [6:0]  m_ctl  [4];
  logic [7:0]  m_cnt  [4];
  logic        m_out  [4];
  logic [7:0]  m_glob;
  logic        m_hp;
  int          m_pre;
  logic [3:0]  m4;
  logic [4:0]  m5;
  logic [8:0]  m9;
  logic [16:0] m17;
  logic        t_tk [4];
  logic        t_uf [4];
  logic        t_slow, t_nl;
  logic [15:0] t_w, t_w2;

  function automatic logic ref_next(logic cur, logic [2:0] w, logic a4, logic a5, logic nl);
    if (w[2]) return w[0] ? (a5 ? nl : cur) : nl;
    case (w[1:0])
      2'b00:   return ~cur;
      2'b01:   return a5 ? ~cur : cur;
      2'b10:   return a4 ? ~cur : cur;
      default: return (a5 & a4) ? ~cur : cur;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_freq[i] <= '0; m_ctl[i] <= '0; m_cnt[i] <= '0; m_out[i] <= 1'b0;
      end
      m_glob <= '0; m_hp <= 1'b0; m_pre <= 0;
      m4 <= '1; m5 <= '1; m9 <= '1; m17 <= '1;
    end else begin
      t_slow = tick_fast && (m_pre == PRE - 1);
      if (tick_fast) m_pre <= (m_pre == PRE - 1) ? 0 : m_pre + 1;
      for (int i = 0; i < 4; i++)
        t_tk[i] = ((i % 2 == 0) ? m_glob[2] : m_glob[5]) ? tick_fast : t_slow;
      for (int p = 0; p < 2; p++) begin
        if (m_glob[p]) begin
          t_w = {m_cnt[2*p+1], m_cnt[2*p]};
          t_uf[2*p] = t_tk[2*p] && (t_w == 0);
          t_uf[2*p+1] = 1'b0;
          if (t_tk[2*p]) begin
            t_w2 = t_uf[2*p] ? {m_freq[2*p+1], m_freq[2*p]} : t_w - 16'd1;
            m_cnt[2*p+1] <= t_w2[15:8];
            m_cnt[2*p]   <= t_w2[7:0];
          end
        end else begin
          for (int k = 2*p; k < 2*p + 2; k++) begin
            t_uf[k] = t_tk[k] && (m_cnt[k] == 0);
            if (t_tk[k]) m_cnt[k] <= t_uf[k] ? m_freq[k] : m_cnt[k] - 8'd1;
          end
        end
      end
      t_nl = m_glob[7] ? m17[0] : m9[0];
      for (int i = 0; i < 4; i++)
        if (t_uf[i]) m_out[i] <= ref_next(m_out[i], m_ctl[i][6:4], m4[0], m5[0], t_nl);
      if (t_uf[1]) m_hp <= m_out[0];
      if (tick_fast) begin
        m4  <= {m4[0] ^ m4[1], m4[3:1]};
        m5  <= {m5[0] ^ m5[2], m5[4:1]};
        m9  <= {m9[0] ^ m9[4], m9[8:1]};
        m17 <= {m17[0] ^ m17[3], m17[16:1]};
      end
      if (wr_en && wr_addr < 8) begin
        if (wr_addr[0]) m_ctl[wr_addr[2:1]]  <= wr_data[6:0];
        else            m_freq[wr_addr[2:1]] <= wr_data;
      end
      if (wr_en && wr_addr == 8) m_glob <= wr_data;
    end
  end

  function automatic logic [3:0] exp_level(int c);
    logic b;
    b = m_out[c];
    if (c == 0 && m_glob[4]) b = b ^ m_hp;
    if ((c == 1 && m_glob[0]) || (c == 3 && m_glob[1])) return 4'd0;
    return b ? m_ctl[c][3:0] : 4'd0;
  endfunction

  function automatic logic [3:0] lev(int c);
    return level_o[c*4 +: 4];
  endfunction

  task automatic chk(string tag, int c, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s ch%0d actual=%0d expected=%0d", tag, c + 1, act, exp);
    end
  endtask

  // continuous comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (cmp_en)
      for (int c = 0; c < 4; c++) chk(phase, c, lev(c), exp_level(c));
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  // cycles between two consecutive level changes of a voice
  task automatic gap(input int c, output int n);
    logic [3:0] prev;
    int lim;
    prev = lev(c); lim = 0;
    while (lev(c) == prev && lim < 5000) begin @(negedge clk); lim++; end
    prev = lev(c); n = 0;
    while (lev(c) == prev && n < 5000) begin @(negedge clk); n++; end
  endtask

  int g;

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    idle(3);
    // R1: reset state
    for (int c = 0; c < 4; c++) chk("R1", c, lev(c), 0);
    rst_n = 1'b1;
    idle(2);
    for (int c = 0; c < 4; c++) chk("R1", c, lev(c), 0);
    cmp_en = 1'b1;
    tick_fast = 1'b1;

    // R3/R4: pure tone, fast base, divider 3
    phase = "R3";
    wr(4'd8, 8'h04); wr(4'd0, 8'd3); wr(4'd1, 8'h09);
    gap(0, g); chk("R3", 0, g, 4);
    gap(0, g); chk("R3", 0, g, 4);
    phase = "R4";
    while (lev(0) == 0) @(negedge clk);
    chk("R4", 0, lev(0), 9);

    // R5: slow base, divider 0 -> one reload per PRE fast enables
    phase = "R5";
    wr(4'd8, 8'h00); wr(4'd0, 8'd0);
    gap(0, g); gap(0, g); chk("R5", 0, g, PRE);
    wr(4'd2, 8'd1); wr(4'd3, 8'h05); wr(4'd8, 8'h20);
    gap(1, g); gap(1, g); chk("R5", 1, g, 2);

    // R6: join voices 1+2, divider 0x0102
    phase = "R6";
    wr(4'd2, 8'd1); wr(4'd3, 8'h07); wr(4'd0, 8'd2); wr(4'd8, 8'h05);
    gap(0, g); gap(0, g); chk("R6", 0, g, 259);
    chk("R6", 1, lev(1), 0);

    // R7: join voices 3+4, divider 0x0005
    phase = "R7";
    wr(4'd4, 8'd5); wr(4'd5, 8'h0C); wr(4'd6, 8'd0); wr(4'd7, 8'h0F); wr(4'd8, 8'h06);
    gap(2, g); gap(2, g); chk("R7", 2, g, 6);
    idle(20); chk("R7", 3, lev(3), 0);

    // R2: offsets above 8 leave everything alone
    phase = "R2";
    for (int a = 9; a < 16; a++) wr(4'(a), 8'hFF);
    chk("R2", 3, lev(3), 0);
    gap(2, g); gap(2, g); chk("R2", 2, g, 6);

    // R8: short polynomial gating
    wr(4'd8, 8'h04); wr(4'd0, 8'd1);
    phase = "R8"; wr(4'd1, 8'h1A); idle(300);
    wr(4'd1, 8'h2A); idle(300);
    wr(4'd1, 8'h3A); idle(300);

    // R9: long noise, 9-bit then 17-bit, plain and gated
    phase = "R9"; wr(4'd1, 8'h4C); idle(300);
    wr(4'd8, 8'h84); idle(300);
    wr(4'd1, 8'h5C); idle(300);
    wr(4'd1, 8'h6C); wr(4'd8, 8'h04); idle(300);

    // R10: high-pass on voice 1 clocked by voice 2
    phase = "R10";
    wr(4'd0, 8'd2); wr(4'd1, 8'h08); wr(4'd2, 8'd6); wr(4'd3, 8'h03);
    wr(4'd8, 8'h34); idle(400);
    wr(4'd2, 8'd2); idle(200);

    // constrained random mix, checked every cycle against the model
    phase = "R3 R5 R8 R9 R10 random";
    for (int n = 0; n < 6000; n++) begin
      tick_fast = ($urandom % 4) != 0;
      if ($urandom % 6 == 0) begin
        wr_en = 1'b1;
        wr_addr = 4'($urandom % 16);
        wr_data = 8'($urandom);
        if (wr_addr < 8 && !wr_addr[0]) wr_data = wr_data & 8'h0F;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule